// File: doc/BRIEF.md
# I2C Write-Only Bus Master with Early Transmit Refill

This block drives an I2C bus as the sole master for write transfers to a slave with a 10-bit address. Software sees three small registers: a byte-wide data register, a four-bit control register and a three-bit status register. One interrupt line completes the software interface. When software sets the start request, the controller issues a start condition, copies the data register into an internal shift register and sends the byte most significant bit first. Two address bytes are sent this way, then any number of data bytes. After each byte it releases SDA for one more clock and checks for the slave's acknowledge.

The data register is declared empty as soon as the first bit of the current byte has left the shift register. This gives software almost a whole byte time to supply the next byte. If the next byte is still missing when an acknowledged byte finishes, the controller stretches the bus by holding SCL low. A not-acknowledge sets a sticky flag and stalls the bus in the same way. Software recovers by requesting stop together with flush. The controller then sends the stop condition, discards any pending byte and clears its own request and error flags.

SCL is derived from the system clock. Each bit lasts four quarter periods of `QTR` clocks each: two with SCL low and two with SCL released. The bus pins are modelled as open-drain pull-down enables, and the SDA level is read back as an input.

Top module: `i2c_wr_master`

## Requirements
- R1: `irq` is high exactly when the transmit-interrupt-enable bit (control bit 3) is set and the data register is empty, or when the not-acknowledge flag is set.
- R2: While the start request (control bit 0) is set and the data register holds a byte, the controller waits for the next bit boundary in idle. It then drives SDA low with SCL released (a start condition). After that it copies the data register into the shift register and clears the start request.
- R3: Bytes are sent most significant bit first, one bit per 4*QTR clocks. SDA changes only while SCL is low, apart from start and stop conditions.
- R4: The data-empty status (status bit 0) sets at the end of the first bit of each byte. A data-register write clears it. It is 1 after reset.
- R5: The acknowledge is sampled in the middle of the SCL-high half of the ninth clock. A low level sets the ACK flag (status bit 1). If a byte is pending and no stop is requested, the controller then reloads the shift register and sends the next byte without a gap.
- R6: A high level at the acknowledge sample sets the not-acknowledge flag (status bit 2) and clears ACK. SCL is then held low until stop is requested.
- R7: When a byte ends (or while stalled) with the stop request (control bit 1) set, the controller sends a stop condition: SDA low, then SCL released, then SDA released. It then returns to idle with both lines released and clears the stop request and the not-acknowledge flag.
- R8: A set flush bit (control bit 2) marks the data register empty and clears itself one clock later.
- R9: If an acknowledged byte finishes with the data register empty and no stop requested, SCL is held low until a byte is written or stop is requested.
- R10: After reset both bus lines are released, the control register is 0, status is 3'b001 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 4 | Control value: bit0 start, bit1 stop, bit2 flush, bit3 tx interrupt enable |
| dat_wr | input | 1 | Write strobe for the data register |
| dat_wdata | input | 8 | Byte to transmit |
| ctl_q | output | 4 | Control register readback |
| stat_q | output | 3 | Status: bit0 data empty, bit1 ACK, bit2 not-acknowledge |
| irq | output | 1 | Interrupt request |
| scl_low_en | output | 1 | Pull SCL low when 1 |
| sda_low_en | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sampled SDA bus level |

## Verification
A wrong bit counter or shift register shows up on SDA within one bit period, as a byte decoded from the bus that differs from the one written. An empty flag updated at the wrong time shows up in `irq` and status bit 0 in the same clock. A wrong ACK decision shows up as SCL staying released, or stalling, within one quarter period of the ninth bit. A behavioural reference in the bench predicts both bus pins, the status, the control readback and the interrupt on every clock, so any divergence is caught in the cycle it first appears.

// File: rtl/i2c_wr_master.sv
module i2c_wr_master #(
  parameter int QTR = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [3:0] ctl_wdata,
  input  logic       dat_wr,
  input  logic [7:0] dat_wdata,
  output logic [3:0] ctl_q,
  output logic [2:0] stat_q,
  output logic       irq,
  output logic       scl_low_en,
  output logic       sda_low_en,
  input  logic       sda_in
);

  localparam int CW = (QTR > 1) ? $clog2(QTR) : 1;

  typedef enum logic [2:0] {S_IDLE, S_START, S_BIT, S_ACK, S_HOLD, S_STOP} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic [1:0]  ph;
  logic [7:0]  sh, dat;
  logic [2:0]  bitn;
  logic        empty, ack, nak, ackbit, sda_q, sda_raw;
  logic        c_start, c_stop, c_flush, c_txie;
  logic        tick, bnd, hold0;

  assign tick   = (cnt == CW'(QTR - 1));
  assign bnd    = tick && (ph == 2'd3);
  assign ctl_q  = {c_txie, c_flush, c_stop, c_start};
  assign stat_q = {nak, ack, empty};
  assign irq    = (c_txie & empty) | nak;

  always_comb begin
    scl_low_en = ~ph[1];
    sda_raw    = 1'b0;
    unique case (st)
      S_IDLE:  scl_low_en = 1'b0;
      S_START: begin scl_low_en = 1'b0; sda_raw = ph[1]; end
      S_BIT:   sda_raw = ~sh[7];
      S_ACK:   sda_raw = 1'b0;
      S_HOLD:  begin scl_low_en = 1'b1; sda_raw = 1'b1; end
      S_STOP:  sda_raw = (ph != 2'd3);
      default: scl_low_en = 1'b0;
    endcase
  end

  assign hold0      = (ph == 2'd0) && (st == S_BIT || st == S_ACK || st == S_HOLD || st == S_STOP);
  assign sda_low_en = hold0 ? sda_q : sda_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ph  <= 2'd0;
    end else if (tick) begin
      cnt <= '0;
      ph  <= ph + 2'd1;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      sh      <= 8'h00;
      dat     <= 8'h00;
      bitn    <= 3'd0;
      empty   <= 1'b1;
      ack     <= 1'b0;
      nak     <= 1'b0;
      ackbit  <= 1'b0;
      sda_q   <= 1'b0;
      c_start <= 1'b0;
      c_stop  <= 1'b0;
      c_flush <= 1'b0;
      c_txie  <= 1'b0;
    end else begin
      sda_q <= sda_low_en;
      if (st == S_ACK && tick && ph == 2'd2) ackbit <= ~sda_in;
      if (bnd) begin
        unique case (st)
          S_IDLE: if (c_start && !empty) st <= S_START;
          S_START: begin
            st      <= S_BIT;
            sh      <= dat;
            bitn    <= 3'd0;
            c_start <= 1'b0;
          end
          S_BIT: begin
            sh   <= {sh[6:0], 1'b0};
            bitn <= bitn + 3'd1;
            if (bitn == 3'd0) empty <= 1'b1;
            if (bitn == 3'd7) st <= S_ACK;
          end
          S_ACK: begin
            if (ackbit) ack <= 1'b1;
            else begin
              nak <= 1'b1;
              ack <= 1'b0;
            end
            if (c_stop) st <= S_STOP;
            else if (ackbit && !empty) begin
              st   <= S_BIT;
              sh   <= dat;
              bitn <= 3'd0;
            end else st <= S_HOLD;
          end
          S_HOLD: begin
            if (c_stop) st <= S_STOP;
            else if (!nak && !empty) begin
              st   <= S_BIT;
              sh   <= dat;
              bitn <= 3'd0;
            end
          end
          S_STOP: begin
            st     <= S_IDLE;
            c_stop <= 1'b0;
            nak    <= 1'b0;
          end
          default: st <= S_IDLE;
        endcase
      end
      if (c_flush) begin
        c_flush <= 1'b0;
        empty   <= 1'b1;
      end
      if (dat_wr) begin
        dat   <= dat_wdata;
        empty <= 1'b0;
      end
      if (ctl_wr) {c_txie, c_flush, c_stop, c_start} <= ctl_wdata;
    end
  end

  a_r3_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BIT && ph[1]) |-> $stable(sda_low_en));

  a_r4_empty_after_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BIT && bnd && bitn == 3'd0 && !dat_wr) |=> stat_q[0]);

  a_r6_nak_excludes_ack: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[2] |-> !stat_q[1]);

  a_r6_nak_holds_scl: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[2] && st != S_STOP) |-> scl_low_en);

  a_r7_stop_ends_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STOP && bnd && !ctl_wr) |=> (!scl_low_en && !sda_low_en && !stat_q[2] && !ctl_q[1]));

  a_r8_flush_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[2] && !ctl_wr && !dat_wr) |=> (!ctl_q[2] && stat_q[0]));

  a_r2_no_start_without_request: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !ctl_q[0]) |=> (st != S_START));

endmodule

// File: tb/i2c_wr_master_bench.sv
module i2c_wr_master_bench;
  localparam int QTR = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       ctl_wr = 1'b0, dat_wr = 1'b0;
  logic [3:0] ctl_wdata = 4'h0;
  logic [7:0] dat_wdata = 8'h00;
  logic [3:0] ctl_q;
  logic [2:0] stat_q;
  logic       irq, scl_low_en, sda_low_en, sda_in;
  logic       slave_pull = 1'b0;
  logic       slave_nak = 1'b0;

  assign sda_in = ~(sda_low_en | slave_pull);

  i2c_wr_master #(.QTR(QTR)) u_i2c_wr_master (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .dat_wr(dat_wr), .dat_wdata(dat_wdata),
    .ctl_q(ctl_q), .stat_q(stat_q), .irq(irq),
    .scl_low_en(scl_low_en), .sda_low_en(sda_low_en), .sda_in(sda_in)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference: modes 0 idle, 1 start, 2 bit, 3 ack, 4 hold, 5 stop
  int   cyc = 0, mmode = 0, mbit = 0, ph = 0, nph = 0;
  logic [7:0] msh = 8'h00, mdat = 8'h00;
  bit   mempty = 1, mack = 0, mnak = 0, msamp = 0;
  bit   mstart = 0, mstop = 0, mflush = 0, mtxie = 0;
  bit   exp_scl = 0, exp_sda = 0, tk = 0, bd = 0, psda = 0, raw = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0; mmode = 0; mbit = 0; msh = 0; mdat = 0;
      mempty = 1; mack = 0; mnak = 0; msamp = 0;
      mstart = 0; mstop = 0; mflush = 0; mtxie = 0;
      exp_scl = 0; exp_sda = 0;
    end else begin
      ph = (cyc / QTR) % 4;
      tk = (cyc % QTR) == QTR - 1;
      bd = tk && ph == 3;
      psda = exp_sda;
      if (mmode == 3 && tk && ph == 2) msamp = !sda_in;
      if (bd) begin
        case (mmode)
          0: if (mstart && !mempty) mmode = 1;
          1: begin mmode = 2; msh = mdat; mbit = 0; mstart = 0; end
          2: begin
            msh = msh << 1;
            if (mbit == 0) mempty = 1;
            mbit++;
            if (mbit == 8) begin mmode = 3; mbit = 0; end
          end
          3: begin
            if (msamp) mack = 1; else begin mnak = 1; mack = 0; end
            if (mstop) mmode = 5;
            else if (msamp && !mempty) begin mmode = 2; msh = mdat; mbit = 0; end
            else mmode = 4;
          end
          4: begin
            if (mstop) mmode = 5;
            else if (!mnak && !mempty) begin mmode = 2; msh = mdat; mbit = 0; end
          end
          default: begin mmode = 0; mstop = 0; mnak = 0; end
        endcase
      end
      if (mflush) begin mflush = 0; mempty = 1; end
      if (dat_wr) begin mdat = dat_wdata; mempty = 0; end
      if (ctl_wr) {mtxie, mflush, mstop, mstart} = ctl_wdata;
      cyc++;
      nph = (cyc / QTR) % 4;
      case (mmode)
        0: begin exp_scl = 0; raw = 0; end
        1: begin exp_scl = 0; raw = (nph >= 2); end
        2: begin exp_scl = (nph < 2); raw = !msh[7]; end
        3: begin exp_scl = (nph < 2); raw = 0; end
        4: begin exp_scl = 1; raw = 1; end
        default: begin exp_scl = (nph < 2); raw = (nph != 3); end
      endcase
      exp_sda = (nph == 0 && mmode >= 2) ? psda : raw;
    end
  end

  function automatic string bus_req(input int m);
    case (m)
      0: return "R10";
      1: return "R2";
      2: return "R3";
      3: return "R5";
      4: return "R9";
      default: return "R7";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(scl_low_en === exp_scl, bus_req(mmode), "scl_low_en", scl_low_en, exp_scl);
      chk(sda_low_en === exp_sda, bus_req(mmode), "sda_low_en", sda_low_en, exp_sda);
      chk(stat_q[0] === mempty, "R4", "empty", stat_q[0], mempty);
      chk(stat_q[1] === mack, "R5", "ack", stat_q[1], mack);
      chk(stat_q[2] === mnak, "R6", "nak", stat_q[2], mnak);
      chk(ctl_q[0] === mstart, "R2", "start bit", ctl_q[0], mstart);
      chk(ctl_q[1] === mstop, "R7", "stop bit", ctl_q[1], mstop);
      chk(ctl_q[2] === mflush, "R8", "flush bit", ctl_q[2], mflush);
      chk(ctl_q[3] === mtxie, "R1", "txie bit", ctl_q[3], mtxie);
      chk(irq === ((mtxie && mempty) || mnak), "R1", "irq", irq, (mtxie && mempty) || mnak);
    end
  end

  // slave: pulls SDA during the acknowledge bit unless told to refuse
  always @(negedge clk) begin
    #1 slave_pull <= (mmode == 3) && !slave_nak;
  end

  // bus monitor: decodes start, stop and bytes from the pins
  byte  got[$];
  int   starts = 0, stops = 0, nb = 0;
  logic [8:0] cur = 9'h0;
  bit   pscl = 1, psd = 1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pscl && !scl_low_en) begin
        if (psd && sda_in == 1'b0) begin starts++; nb = 0; end
        if (!psd && sda_in == 1'b1) stops++;
      end
      if (!pscl && !scl_low_en) begin
        cur = {cur[7:0], sda_in};
        nb++;
        if (nb == 9) begin got.push_back(cur[8:1]); nb = 0; end
      end
      pscl = !scl_low_en;
      psd = sda_in;
    end
  end

  task automatic wr_ctl(input logic [3:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic wr_dat(input logic [7:0] v);
    @(negedge clk); dat_wr = 1'b1; dat_wdata = v;
    @(negedge clk); dat_wr = 1'b0;
  endtask

  task automatic wait_for(input int mode, input bit need_empty, input string req);
    int n = 0;
    while (!(mmode == mode && (!need_empty || mempty)) && n < 3000) begin
      @(negedge clk); n++;
    end
    chk(n < 3000, req, "wait for mode", mmode, mode);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  byte exp_bytes[$];

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(scl_low_en == 0 && sda_low_en == 0, "R10", "lines released", {scl_low_en, sda_low_en}, 0);
    chk(stat_q == 3'b001, "R10", "status", stat_q, 3'b001);
    chk(ctl_q == 4'h0 && irq == 0, "R10", "ctl/irq", {ctl_q, irq}, 0);

    // R1 interrupt on empty with enable
    wr_ctl(4'b1000);
    @(negedge clk);
    chk(irq == 1, "R1", "irq empty+txie", irq, 1);

    // first transfer: two address bytes, data with a stall, stop
    exp_bytes = '{8'hF2, 8'h5A, 8'hC3, 8'h3C, 8'hF0};
    wr_dat(8'hF2);
    chk(irq == 0, "R1", "irq after load", irq, 0);
    wr_ctl(4'b1001);
    wait_for(2, 1, "R4");
    wr_dat(8'h5A);
    wait_for(2, 1, "R4");
    wr_dat(8'hC3);
    wait_for(4, 0, "R9");
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chk(scl_low_en == 1, "R9", "scl held during stall", scl_low_en, 1);
    end
    wr_dat(8'h3C);
    wait_for(2, 1, "R5");
    wr_ctl(4'b1010);
    wait_for(0, 0, "R7");
    chk(stat_q[1] == 1, "R5", "ack flag after transfer", stat_q[1], 1);
    chk(ctl_q[1] == 0, "R7", "stop cleared", ctl_q[1], 0);

    // second transfer: slave refuses the first address byte
    slave_nak = 1'b1;
    wr_dat(8'hF0);
    wr_ctl(4'b1001);
    wait_for(4, 0, "R6");
    @(negedge clk);
    chk(stat_q == 3'b101, "R6", "nak status", stat_q, 3'b101);
    chk(irq == 1, "R6", "irq on nak", irq, 1);
    repeat (30) @(negedge clk);
    chk(scl_low_en == 1, "R6", "scl held after nak", scl_low_en, 1);
    wr_ctl(4'b0110);
    wait_for(0, 0, "R7");
    slave_nak = 1'b0;
    @(negedge clk);
    chk(stat_q[2] == 0 && ctl_q[2:1] == 2'b00, "R7", "nak/stop/flush cleared", {stat_q[2], ctl_q[2:1]}, 0);
    chk(scl_low_en == 0 && sda_low_en == 0, "R7", "idle lines", {scl_low_en, sda_low_en}, 0);

    // flush a pending byte while idle
    wr_dat(8'h77);
    chk(stat_q[0] == 0, "R4", "write clears empty", stat_q[0], 0);
    chk(irq == 0, "R1", "irq low with txie off", irq, 0);
    wr_ctl(4'b0100);
    @(negedge clk);
    chk(stat_q[0] == 1 && ctl_q[2] == 0, "R8", "flush empties and clears", {stat_q[0], ctl_q[2]}, 2'b10);
    chk(irq == 0, "R1", "irq masked", irq, 0);
    wr_ctl(4'b1000);
    @(negedge clk);
    chk(irq == 1, "R1", "irq unmasked", irq, 1);

    // bus decode
    chk(starts == 2, "R2", "start conditions", starts, 2);
    chk(stops == 2, "R7", "stop conditions", stops, 2);
    chk(got.size() == exp_bytes.size(), "R3", "byte count", got.size(), exp_bytes.size());
    for (int i = 0; i < exp_bytes.size() && i < got.size(); i++)
      chk(got[i] == exp_bytes[i], "R3", "byte on bus", got[i], exp_bytes[i]);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule